// File: doc/BRIEF.md
# I2S receive-side bit and frame clock generator

This block drives the serial bit clock and the left/right frame clock of an audio receive port when that port is the clock master. A reference enable, `tick_i`, arrives from an external divider. Each tick is one half period of the bit clock. A rate code sets the number of bit periods in each frame. The code either picks a fixed frame length or defers to the configured word length. With the word-length path and 24-bit words, the block can hold the bit clock still for the unused tail of each 32-bit word slot.

Alongside the two clocks the block gives the deserializer two single-cycle markers. One shows where each data bit should be captured. The other shows where each channel word begins. Configuration is sampled only when a new frame begins, so a frame in progress always finishes in the shape it started with. With the master input low, both clocks rest and the counters return to the start of the left word.

Top module: `i2s_bclk_gen`

## Requirements
- R1: With `rate_sel_i` = 01, 10 or 11, a frame is 32, 64 or 128 bit periods respectively, whatever `wlen_i` and `gate_ctl_i` hold.
- R2: With `rate_sel_i` = 00, the frame length follows `wlen_i`, encoded 00 = 16-bit, 01 = 24-bit, 10 = 32-bit and 11 = 32-bit. 16-bit words give 32 bit periods per frame. 24-bit and 32-bit words give 64.
- R3: With `rate_sel_i` = 00, `wlen_i` = 01 and `gate_ctl_i` = 0, bit periods 24 to 31 of each word are suppressed. During them the bit clock stays at its idle level and no bit strobe occurs, so a frame carries 48 strobes.
- R4: With `gate_ctl_i` = 1, or with any rate code other than 00, no bit period is suppressed.
- R5: One clock after `master_i` is sampled low, the bit clock is at its idle level and the frame clock is low. No strobe is issued while `master_i` stays low.
- R6: With `pol_i` = 1, the bit clock is high in the first half of each active bit period and low in the second half. With `pol_i` = 0 these levels are swapped. The idle level is always the inverse of `pol_i`.
- R7: The frame clock is low for the left word (the first half of the frame) and high for the right word. It changes together with the launch edge of the first bit of a word.
- R8: A change to `rate_sel_i`, `wlen_i`, `gate_ctl_i` or `pol_i` in the middle of a frame takes effect only at the start of the next frame.
- R9: `bit_stb_o` is high for one clock in the first cycle of the second half of each active bit period. `word_stb_o` is high for one clock in the first cycle of bit 0 of each word. The two never coincide.
- R10: During reset both clocks sit at their idle levels and both strobes are low. The first tick with `master_i` high starts bit 0 of the left word.
- R11: Each tick advances the bit clock by one half period. Without a tick, the bit clock, the frame clock and the position in the frame hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-bit-period enable from the reference divider |
| master_i | input | 1 | 1: generate clocks; 0: idle |
| rate_sel_i | input | 2 | Frame length code (00 = follow word length) |
| wlen_i | input | 2 | Word length: 00 = 16, 01 = 24, 10/11 = 32 |
| gate_ctl_i | input | 1 | 0: suppress the 24-bit word tail; 1: run every bit |
| pol_i | input | 1 | Bit clock polarity |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock, low = left word |
| bit_stb_o | output | 1 | Per-bit sample strobe |
| word_stb_o | output | 1 | Word start strobe |

## Verification
A frame wrap and a configuration change can fall in the same cycle. The bench provokes this by changing the rate code mid-frame, changing it again on the same tick that closes a frame, and dropping `master_i` partway through a word. A behavioural reference model applies the new settings only at frame start. It is compared with every output on every clock. Strobes are also counted per frame, and those totals are judged against the lengths that R1 to R4 give for each mode.

// File: rtl/i2s_bclk_pkg.sv
package i2s_bclk_pkg;
  parameter int MAX_FRAME_BITS = 128;
  localparam int CNT_W = $clog2(MAX_FRAME_BITS);

  typedef enum logic [1:0] {
    WL_16  = 2'b00,
    WL_24  = 2'b01,
    WL_32  = 2'b10,
    WL_32X = 2'b11
  } wlen_e;

  typedef struct packed {
    logic [CNT_W-1:0] half; // bits per word
    logic             gate; // tail suppression armed
    logic             pol;
  } cfg_t;

  function automatic logic bit_active(input logic [CNT_W-1:0] cnt,
                                      input cfg_t cfg,
                                      input logic [CNT_W-1:0] gate_from);
    logic [CNT_W-1:0] idx;
    idx = (cnt >= cfg.half) ? cnt - cfg.half : cnt;
    return !(cfg.gate && (idx >= gate_from));
  endfunction
endpackage

// File: rtl/i2s_bclk_cfg.sv
module i2s_bclk_cfg
  import i2s_bclk_pkg::*;
#(
  parameter int BASE_BITS = 32
) (
  input  logic [1:0] rate_sel_i,
  input  logic [1:0] wlen_i,
  input  logic       gate_ctl_i,
  input  logic       pol_i,
  output cfg_t       cfg_o
);
  localparam int BASE_HALF = BASE_BITS / 2;
  localparam logic [CNT_W-1:0] HALF0 = CNT_W'(BASE_HALF);

  logic [CNT_W-1:0] half_tab [4];

  // fixed codes double the frame per step; code 0 is replaced below
  for (genvar g = 0; g < 4; g++) begin : g_rate
    if (g == 0) begin : g_zero
      assign half_tab[g] = HALF0;
    end else begin : g_fix
      assign half_tab[g] = HALF0 << (g - 1);
    end
  end

  always_comb begin
    cfg_o.pol  = pol_i;
    cfg_o.gate = 1'b0;
    if (rate_sel_i == 2'b00) begin
      cfg_o.half = (wlen_e'(wlen_i) == WL_16) ? HALF0 : (HALF0 << 1);
      cfg_o.gate = (wlen_e'(wlen_i) == WL_24) && !gate_ctl_i;
    end else begin
      cfg_o.half = half_tab[rate_sel_i];
    end
  end
endmodule

// File: rtl/i2s_bclk_seq.sv
module i2s_bclk_seq
  import i2s_bclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             master_i,
  input  cfg_t             cfg_live_i,
  output logic             run_q_o,
  output cfg_t             cfg_q_o,
  output logic             run_d_o,
  output logic             phase_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output cfg_t             cfg_d_o,
  output logic             adv_o
);
  logic             run_q, phase_q;
  logic [CNT_W-1:0] cnt_q;
  cfg_t             cfg_q;
  logic             run_d, phase_d;
  logic [CNT_W-1:0] cnt_d;
  cfg_t             cfg_d;
  logic             adv, last_bit;

  assign last_bit = ({1'b0, cnt_q} == ({cfg_q.half, 1'b0} - (CNT_W+1)'(1)));

  always_comb begin
    run_d   = run_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cfg_d   = cfg_q;
    adv     = 1'b0;
    if (!master_i) begin
      run_d   = 1'b0;
      phase_d = 1'b0;
      cnt_d   = '0;
      cfg_d   = cfg_live_i;
    end else if (tick_i) begin
      adv = 1'b1;
      if (!run_q) begin
        run_d   = 1'b1;
        phase_d = 1'b0;
        cnt_d   = '0;
        cfg_d   = cfg_live_i;
      end else if (!phase_q) begin
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        if (last_bit) begin
          cnt_d = '0;
          cfg_d = cfg_live_i; // frame boundary: new settings
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (!run_q) begin
      cfg_d = cfg_live_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      cfg_q   <= '0;
    end else begin
      run_q   <= run_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
    end
  end

  assign run_q_o   = run_q;
  assign cfg_q_o   = cfg_q;
  assign run_d_o   = run_d;
  assign phase_d_o = phase_d;
  assign cnt_d_o   = cnt_d;
  assign cfg_d_o   = cfg_d;
  assign adv_o     = adv;

  AST_CNT_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ({1'b0, cnt_q} < {cfg_q.half, 1'b0})); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !tick_i && run_q) |=> ($stable(cnt_q) && $stable(phase_q))); // R11

  AST_CFG_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && !(cnt_q == '0 && !phase_q)) |-> $stable(cfg_q)); // R8
endmodule

// File: rtl/i2s_bclk_out.sv
module i2s_bclk_out
  import i2s_bclk_pkg::*;
#(
  parameter int GATE_FROM = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_q_i,
  input  cfg_t             cfg_q_i,
  input  logic             run_d_i,
  input  logic             phase_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  cfg_t             cfg_d_i,
  input  logic             adv_i,
  input  logic             pol_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             bit_stb_o,
  output logic             word_stb_o
);
  localparam logic [CNT_W-1:0] GATE_IDX = CNT_W'(GATE_FROM);

  logic raw_q, lr_q, bs_q, ws_q;
  logic act_d, pol_sel;

  assign act_d = bit_active(cnt_d_i, cfg_d_i, GATE_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      lr_q  <= 1'b0;
      bs_q  <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      raw_q <= run_d_i && !phase_d_i && act_d;
      lr_q  <= run_d_i && (cnt_d_i >= cfg_d_i.half);
      bs_q  <= adv_i && run_d_i && phase_d_i && act_d;
      ws_q  <= adv_i && run_d_i && !phase_d_i &&
               ((cnt_d_i == '0) || (cnt_d_i == cfg_d_i.half));
    end
  end

  // idle level tracks the live polarity until a frame latches it
  assign pol_sel    = run_q_i ? cfg_q_i.pol : pol_i;
  assign bclk_o     = pol_sel ? raw_q : !raw_q;
  assign lrclk_o    = lr_q;
  assign bit_stb_o  = bs_q;
  assign word_stb_o = ws_q;

  AST_SAMPLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_q |-> !raw_q); // R9

  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q_i |-> (!raw_q && !lr_q && !bs_q)); // R5
endmodule

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen
  import i2s_bclk_pkg::*;
#(
  parameter int BASE_BITS = 32,
  parameter int GATE_FROM = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       master_i,
  input  logic [1:0] rate_sel_i,
  input  logic [1:0] wlen_i,
  input  logic       gate_ctl_i,
  input  logic       pol_i,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       bit_stb_o,
  output logic       word_stb_o
);
  cfg_t             cfg_live, cfg_q, cfg_d;
  logic             run_q, run_d, phase_d, adv;
  logic [CNT_W-1:0] cnt_d;

  i2s_bclk_cfg #(.BASE_BITS(BASE_BITS)) u_cfg (
    .rate_sel_i (rate_sel_i),
    .wlen_i     (wlen_i),
    .gate_ctl_i (gate_ctl_i),
    .pol_i      (pol_i),
    .cfg_o      (cfg_live)
  );

  i2s_bclk_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .master_i   (master_i),
    .cfg_live_i (cfg_live),
    .run_q_o    (run_q),
    .cfg_q_o    (cfg_q),
    .run_d_o    (run_d),
    .phase_d_o  (phase_d),
    .cnt_d_o    (cnt_d),
    .cfg_d_o    (cfg_d),
    .adv_o      (adv)
  );

  i2s_bclk_out #(.GATE_FROM(GATE_FROM)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_q_i    (run_q),
    .cfg_q_i    (cfg_q),
    .run_d_i    (run_d),
    .phase_d_i  (phase_d),
    .cnt_d_i    (cnt_d),
    .cfg_d_i    (cfg_d),
    .adv_i      (adv),
    .pol_i      (pol_i),
    .bclk_o     (bclk_o),
    .lrclk_o    (lrclk_o),
    .bit_stb_o  (bit_stb_o),
    .word_stb_o (word_stb_o)
  );

  AST_STROBES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_stb_o && word_stb_o)); // R9

  AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (!bit_stb_o && !word_stb_o && !lrclk_o && (bclk_o == !pol_i))); // R5
endmodule

// File: tb/i2s_bclk_gen_test.sv
module i2s_bclk_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, master = 1'b0, gate_ctl = 1'b0, pol = 1'b1;
  logic [1:0] rate = 2'b01, wlen = 2'b00;
  logic bclk, lrclk, bit_stb, word_stb;

  int total = 0, bad = 0;
  string cur_tag = "R10";
  int tick_div = 1;

  always #4 clk = ~clk;

  i2s_bclk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .master_i(master),
    .rate_sel_i(rate), .wlen_i(wlen), .gate_ctl_i(gate_ctl), .pol_i(pol),
    .bclk_o(bclk), .lrclk_o(lrclk), .bit_stb_o(bit_stb), .word_stb_o(word_stb)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_run = 0, m_phase = 0, m_pos = 0, m_half = 16, m_gate = 0, m_pol = 0;
  bit  e_raw = 0, e_lr = 0, e_bs = 0, e_ws = 0;

  function automatic bit m_act(int pos, int half, int g);
    int idx = pos % half;
    return !(g != 0 && idx >= 24);
  endfunction

  task automatic m_load();
    case (rate)
      2'd1: m_half = 16;
      2'd2: m_half = 32;
      2'd3: m_half = 64;
      default: m_half = (wlen == 2'd0) ? 16 : 32;
    endcase
    m_gate = (rate == 2'd0 && wlen == 2'd1 && !gate_ctl) ? 1 : 0;
    m_pol  = pol;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_phase = 0; m_pos = 0; m_half = 16; m_gate = 0; m_pol = 0;
      e_bs = 0; e_ws = 0;
    end else begin
      e_bs = 0; e_ws = 0;
      if (!master) begin
        m_run = 0; m_phase = 0; m_pos = 0; m_load();
      end else if (tick) begin
        if (m_run == 0) begin
          m_run = 1; m_phase = 0; m_pos = 0; m_load(); e_ws = 1;
        end else if (m_phase == 0) begin
          m_phase = 1; e_bs = m_act(m_pos, m_half, m_gate);
        end else begin
          m_phase = 0; m_pos++;
          if (m_pos == 2 * m_half) begin m_pos = 0; m_load(); end
          e_ws = (m_pos % m_half) == 0;
        end
      end else if (m_run == 0) begin
        m_load();
      end
    end
    e_raw = m_run != 0 && m_phase == 0 && m_act(m_pos, m_half, m_gate);
    e_lr  = m_run != 0 && m_pos >= m_half;
  end

  // -------- per-clock comparison and per-frame strobe counting --------
  int frames_seen = 0, cur_cnt = 0, last_frame = -1, have_start = 0;

  always @(posedge clk) begin
    bit pe, eb;
    #2;
    pe = (m_run != 0) ? (m_pol != 0) : pol;
    eb = pe ? e_raw : !e_raw;
    total++;
    if (bclk !== eb || lrclk !== e_lr || bit_stb !== e_bs || word_stb !== e_ws) begin
      bad++;
      $display("FAIL %s per-clock {bclk,lr,bs,ws} actual=%b%b%b%b expected=%b%b%b%b",
               cur_tag, bclk, lrclk, bit_stb, word_stb, eb, e_lr, e_bs, e_ws);
    end
    if (!master || !rst_n) begin
      have_start = 0; cur_cnt = 0;
    end else begin
      if (word_stb && !lrclk) begin
        if (have_start != 0) begin last_frame = cur_cnt; frames_seen++; end
        have_start = 1; cur_cnt = 0;
      end
      if (bit_stb) cur_cnt++;
    end
  end

  // tick generator: one tick every tick_div clocks
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
      tick = (ph == 0);
    end
  end

  task automatic wait_frames(input int n);
    int target = frames_seen + n;
    while (frames_seen < target) @(negedge clk);
  endtask

  task automatic mode(input string tag, input logic [1:0] r, input logic [1:0] w,
                      input logic g, input int exp_bits);
    @(negedge clk);
    rate = r; wlen = w; gate_ctl = g; cur_tag = tag;
    wait_frames(3);
    check(tag, "strobes per frame", last_frame, exp_bits);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset state, idle level follows polarity
    repeat (3) @(negedge clk);
    check("R10", "bclk idle pol1", bclk, 0);
    check("R10", "lrclk reset", lrclk, 0);
    check("R10", "strobes reset", bit_stb | word_stb, 0);
    pol = 1'b0; #1;
    check("R10", "bclk idle pol0", bclk, 1);
    pol = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: fixed frame lengths, word length ignored
    master = 1'b1; cur_tag = "R1/R10";
    mode("R1", 2'b01, 2'b10, 1'b0, 32);
    mode("R1", 2'b10, 2'b00, 1'b0, 64);
    mode("R1", 2'b11, 2'b01, 1'b1, 128);
    // R2: word-length driven lengths
    mode("R2", 2'b00, 2'b00, 1'b1, 32);
    mode("R2", 2'b00, 2'b10, 1'b0, 64);
    mode("R2", 2'b00, 2'b11, 1'b0, 64);
    // R3 / R4: tail gating
    mode("R3", 2'b00, 2'b01, 1'b0, 48);
    mode("R4", 2'b00, 2'b01, 1'b1, 64);
    mode("R4", 2'b01, 2'b01, 1'b0, 32);
    mode("R4", 2'b10, 2'b01, 1'b0, 64);

    // R6 / R11: negative polarity with a slower tick
    @(negedge clk); pol = 1'b0; tick_div = 3;
    mode("R6/R11", 2'b00, 2'b01, 1'b0, 48);
    @(negedge clk); tick_div = 1; pol = 1'b1;
    mode("R6/R7", 2'b01, 2'b00, 1'b0, 32);

    // R8: mid-frame change keeps the current frame
    cur_tag = "R8";
    while (!(word_stb && !lrclk)) @(negedge clk);
    repeat (10) @(negedge clk);
    rate = 2'b10; pol = 1'b0;
    wait_frames(1);
    check("R8", "frame after mid-frame change", last_frame, 32);
    wait_frames(1);
    check("R8", "next frame uses new rate", last_frame, 64);
    // change coinciding with a frame wrap
    while (!(word_stb && !lrclk)) @(negedge clk);
    repeat (255) @(negedge clk);
    rate = 2'b01;
    wait_frames(2);
    check("R8", "frame after wrap-edge change", last_frame, 32);

    // R5: master drop mid-word
    cur_tag = "R5";
    repeat (21) @(negedge clk);
    master = 1'b0;
    @(negedge clk);
    check("R5", "bclk idle after drop", bclk, 1);
    check("R5", "lrclk low after drop", lrclk, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R5", "no strobes as slave", bit_stb | word_stb, 0);
    end
    // R10: restart at left word bit 0
    cur_tag = "R10"; pol = 1'b1;
    master = 1'b1;
    while (!word_stb) @(negedge clk);
    check("R10", "restart on left word", lrclk, 0);
    check("R10", "restart launch level", bclk, 1);
    mode("R9", 2'b00, 2'b00, 1'b0, 32);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule